// File: doc/BRIEF.md
# SPI Target Serial Front End with Pause Control

This block is the serial edge of a memory-style SPI target. The host's select, serial clock, data input and pause signals are brought into a fast system clock through synchroniser stages. Clock edges are then found by comparing the synchronised level with a registered copy. Incoming bits are assembled into bytes, most significant bit first, and handed to a command engine with a one-cycle valid strobe. Outgoing bytes are taken from the engine and shifted out, most significant bit first, on a data line that has its own output enable.

Only clock modes 0 and 3 are accepted. The clock level present when select falls identifies the mode. A low pause input freezes the transfer at any bit position and floats the output. Releasing it continues from exactly the bit where the transfer stopped. Every pause change is acted on only while the serial clock is low. The engine learns when a frame opens and closes from single-cycle pulses. A request pulse tells it when the next outgoing byte must be ready.

Top module: `spi_pause_frontend`

## Requirements
- R1: Once reset is released, the output enable is low and the byte-valid, byte-request, frame-open and frame-close pulses are all low.
- R2: The input bit is captured on each rising serial clock edge, most significant bit first. When the eighth bit of a byte is captured, `rx_valid` is high for exactly one system cycle and `rx_byte` holds the whole byte.
- R3: The outgoing byte is shifted out most significant bit first. The data line moves on falling serial clock edges. In mode 0 (clock low at select fall), the most significant bit is on the line before the first rising edge.
- R4: In mode 3 (clock high at select fall), the first falling edge of a frame only loads the outgoing byte and shifts nothing. The first bit put out is therefore the byte's most significant bit.
- R5: While select is high, serial clock edges produce no byte and the output enable is low. Raising select in the middle of a byte discards the partial byte, and the next frame starts at a byte boundary.
- R6: While paused, neither the bit position nor either shift register changes, whatever the serial clock and data lines do. After release, reception and transmission continue at the same bit position.
- R7: While paused, the output enable is low and select transitions are ignored. A select pulse during a pause produces no frame-close pulse and does not abort the byte.
- R8: A pause input change that starts and ends while the serial clock is high has no effect on the transfer.
- R9: The output enable is high inside a frame only for bytes loaded while `tx_drive` was 1. The engine's `tx_byte` and `tx_drive` are sampled at each load: one system cycle after the frame-open pulse in mode 0, and at the first falling edge of every other byte.
- R10: `frame_start` and `frame_end` pulse for one cycle when select falls and rises. `tx_req` pulses at frame open and after every completed byte. The output enable is low in the cycles of both frame pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel_n | input | 1 | Host select, active low |
| host_sck | input | 1 | Host serial clock |
| host_din | input | 1 | Host serial data into the block |
| host_pause_n | input | 1 | Host pause request, active low |
| tx_byte | input | BYTE_W | Next outgoing byte from the command engine |
| tx_drive | input | 1 | Engine asks for the output to be driven for that byte |
| host_dout | output | 1 | Serial data out to the host |
| host_dout_oe | output | 1 | Output enable for `host_dout`; low means tri-stated |
| rx_byte | output | BYTE_W | Last complete received byte |
| rx_valid | output | 1 | One-cycle strobe, `rx_byte` is new |
| tx_req | output | 1 | One-cycle request for the next outgoing byte |
| frame_start | output | 1 | One-cycle pulse when a frame opens |
| frame_end | output | 1 | One-cycle pulse when a frame closes |

## Verification
The bench uses the defaults: 8-bit bytes and two synchroniser stages. The serial clock runs at one sixteenth of the system clock. This leaves room to sample the output line half a serial period after each falling edge, and still catch the request-to-load window. With these values, a pause can be placed at a chosen bit while the clock keeps toggling underneath it, and a select pulse can be placed inside that pause. A pause glitch can be fitted wholly inside a clock-high phase, and a frame can be aborted after three bits. Each of these is then followed by a full byte whose received value and transmitted bits are compared against the values the bench intended to send.

// File: rtl/spf_pkg.sv
package spf_pkg;

    // Registered view of the host lines after pause gating.
    typedef struct packed {
        logic held;   // pause is in force
        logic sel;    // gated select level (1 = idle)
        logic sck;    // gated serial clock level
    } gate_st_t;

    // Events handed from the gate to the shift engine.
    typedef struct packed {
        logic rise;     // capture edge inside a frame
        logic fall;     // launch edge inside a frame
        logic start;    // select went low
        logic stop;     // select went high
        logic frame;    // frame open
        logic held;     // transfer paused
        logic sck_lvl;  // clock level now (mode at start)
    } gate_ev_t;

endpackage

// File: rtl/spf_sync.sv
module spf_sync #(
    parameter int              WIDTH   = 4,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stage_q [STAGES];
    logic [WIDTH-1:0] stage_d [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_comb stage_d[s] = d_i;
            end else begin : g_next
                always_comb stage_d[s] = stage_q[s-1];
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= RST_VAL;
                else        stage_q[s] <= stage_d[s];
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/spf_hold_gate.sv
module spf_hold_gate
    import spf_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     sel_n_s,
    input  logic     sck_s,
    input  logic     pause_n_s,
    output gate_ev_t ev_o
);

    gate_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        // Pause state follows the pin only while the clock is low.
        if (!sck_s) st_d.held = !pause_n_s;
        // Select and clock are tracked only when not paused.
        if (!st_q.held) begin
            st_d.sel = sel_n_s;
            st_d.sck = sck_s;
        end

        ev_o.held    = st_q.held;
        ev_o.frame   = !st_q.sel;
        ev_o.rise    = !st_q.held && !st_q.sel &&  sck_s && !st_q.sck;
        ev_o.fall    = !st_q.held && !st_q.sel && !sck_s &&  st_q.sck;
        ev_o.start   = !st_q.held &&  st_q.sel && !sel_n_s;
        ev_o.stop    = !st_q.held && !st_q.sel &&  sel_n_s;
        ev_o.sck_lvl = sck_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.held <= 1'b0;
            st_q.sel  <= 1'b1;
            st_q.sck  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_PAUSE_FREEZES_LINES: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.held |=> $stable(st_q.sel) && $stable(st_q.sck)); // R7

    AST_PAUSE_CHANGES_CLOCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(st_q.held) || $fell(st_q.held)) |-> !$past(sck_s)); // R8

endmodule

// File: rtl/spf_shifter.sv
module spf_shifter
    import spf_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  gate_ev_t          ev_i,
    input  logic              din_s,
    input  logic [BYTE_W-1:0] tx_byte_i,
    input  logic              tx_drive_i,
    output logic [BYTE_W-1:0] rx_byte_o,
    output logic              rx_valid_o,
    output logic              tx_req_o,
    output logic              frame_start_o,
    output logic              frame_end_o,
    output logic              dout_o,
    output logic              dout_oe_o
);

    localparam int                CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0]  LAST  = CNT_W'(BYTE_W - 1);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] rx_sh;
        logic [BYTE_W-1:0] tx_sh;
        logic              drive;
        logic              load_pend;
        logic [BYTE_W-1:0] rx_byte;
        logic              rx_valid;
        logic              tx_req;
        logic              fstart;
        logic              fend;
    } shf_st_t;

    shf_st_t q, d;

    always_comb begin
        d           = q;
        d.rx_valid  = 1'b0;
        d.tx_req    = 1'b0;
        d.fstart    = 1'b0;
        d.fend      = 1'b0;
        d.load_pend = 1'b0;

        if (ev_i.start) begin
            d.cnt       = '0;
            d.drive     = 1'b0;
            d.fstart    = 1'b1;
            d.tx_req    = 1'b1;
            d.load_pend = !ev_i.sck_lvl;   // mode 0 needs the MSB at once
        end

        if (q.load_pend) begin
            d.tx_sh = tx_byte_i;
            d.drive = tx_drive_i;
        end

        if (ev_i.stop) begin
            d.cnt   = '0;
            d.drive = 1'b0;
            d.fend  = 1'b1;
        end

        if (ev_i.rise) begin
            d.rx_sh = {q.rx_sh[BYTE_W-2:0], din_s};
            if (q.cnt == LAST) begin
                d.cnt      = '0;
                d.rx_byte  = {q.rx_sh[BYTE_W-2:0], din_s};
                d.rx_valid = 1'b1;
                d.tx_req   = 1'b1;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end

        if (ev_i.fall) begin
            if (q.cnt == '0) begin
                // First launch edge of a byte: load, do not shift.
                d.tx_sh = tx_byte_i;
                d.drive = tx_drive_i;
            end else begin
                d.tx_sh = {q.tx_sh[BYTE_W-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rx_byte_o     = q.rx_byte;
    assign rx_valid_o    = q.rx_valid;
    assign tx_req_o      = q.tx_req;
    assign frame_start_o = q.fstart;
    assign frame_end_o   = q.fend;
    assign dout_o        = q.tx_sh[BYTE_W-1];
    assign dout_oe_o     = q.drive && ev_i.frame && !ev_i.held;

    AST_VALID_FOLLOWS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        q.rx_valid |-> $past(ev_i.rise)); // R2

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        q.rx_valid |=> !q.rx_valid); // R2

    AST_SHIFT_FROZEN_PAUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_i.held && $past(ev_i.held) && !$past(q.load_pend))
        |-> $stable(q.cnt) && $stable(q.tx_sh) && $stable(q.rx_sh)); // R6

endmodule

// File: rtl/spi_pause_frontend.sv
module spi_pause_frontend
    import spf_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_sel_n,
    input  logic              host_sck,
    input  logic              host_din,
    input  logic              host_pause_n,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              tx_drive,
    output logic              host_dout,
    output logic              host_dout_oe,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_valid,
    output logic              tx_req,
    output logic              frame_start,
    output logic              frame_end
);

    localparam int          N_IN    = 4;
    // Order: select, pause, clock, data. Idle levels at reset.
    localparam logic [N_IN-1:0] IN_IDLE = 4'b1100;

    logic [N_IN-1:0] raw_in;
    logic [N_IN-1:0] syn_in;
    gate_ev_t        ev;

    assign raw_in = {host_sel_n, host_pause_n, host_sck, host_din};

    spf_sync #(
        .WIDTH   (N_IN),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (IN_IDLE)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_in),
        .q_o   (syn_in)
    );

    spf_hold_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_n_s   (syn_in[3]),
        .sck_s     (syn_in[1]),
        .pause_n_s (syn_in[2]),
        .ev_o      (ev)
    );

    spf_shifter #(
        .BYTE_W (BYTE_W)
    ) u_shift (
        .clk           (clk),
        .rst_n         (rst_n),
        .ev_i          (ev),
        .din_s         (syn_in[0]),
        .tx_byte_i     (tx_byte),
        .tx_drive_i    (tx_drive),
        .rx_byte_o     (rx_byte),
        .rx_valid_o    (rx_valid),
        .tx_req_o      (tx_req),
        .frame_start_o (frame_start),
        .frame_end_o   (frame_end),
        .dout_o        (host_dout),
        .dout_oe_o     (host_dout_oe)
    );

    AST_OPEN_NOT_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> !host_dout_oe); // R10

    AST_CLOSE_TRISTATED: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |-> !host_dout_oe); // R5

endmodule

// File: tb/spi_pause_frontend_tb.sv
`timescale 1ns/1ps
module spi_pause_frontend_tb;

    localparam time HP = 40ns;   // serial half period

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_n = 1'b1;
    logic       sck = 1'b0;
    logic       din = 1'b0;
    logic       pause_n = 1'b1;
    logic [7:0] tx_byte = 8'h00;
    logic       tx_drive = 1'b0;
    logic       host_dout, host_dout_oe, rx_valid, tx_req, frame_start, frame_end;
    logic [7:0] rx_byte;

    int n_chk = 0;
    int n_fail = 0;
    int rx_n = 0;
    int n_fs = 0, n_fe = 0, n_req = 0;
    bit oe_seen = 0;
    logic [7:0] rx_log [0:63];
    bit mode3 = 0;

    always #2.5ns clk = ~clk;

    spi_pause_frontend u_dut (
        .clk(clk), .rst_n(rst_n),
        .host_sel_n(sel_n), .host_sck(sck), .host_din(din), .host_pause_n(pause_n),
        .tx_byte(tx_byte), .tx_drive(tx_drive),
        .host_dout(host_dout), .host_dout_oe(host_dout_oe),
        .rx_byte(rx_byte), .rx_valid(rx_valid), .tx_req(tx_req),
        .frame_start(frame_start), .frame_end(frame_end)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid) begin
                rx_log[rx_n[5:0]] = rx_byte;
                rx_n++;
            end
            if (frame_start) n_fs++;
            if (frame_end)   n_fe++;
            if (tx_req)      n_req++;
            if (host_dout_oe) oe_seen = 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic frame_begin(input bit m3, input logic [7:0] first_tx, input bit drv);
        mode3 = m3;
        tx_byte = first_tx;
        tx_drive = drv;
        sck = m3;
        #(2*HP);
        sel_n = 1'b0;
        #HP;
    endtask

    task automatic frame_finish();
        if (!mode3) begin
            sck = 1'b0;
            #HP;
        end
        sel_n = 1'b1;
        #(2*HP);
    endtask

    // hold_bit: bit index where a pause is placed (-1 none); cs_in_hold adds a
    // select pulse during it; glitch_bit: pause pulse inside a clock-high phase.
    task automatic xfer(input logic [7:0] mosi, input logic [7:0] txv, input bit drv,
                        input int hold_bit, input bit cs_in_hold, input int glitch_bit,
                        output logic [7:0] miso, output bit oe_ok);
        oe_ok = 1;
        tx_byte = txv;
        tx_drive = drv;
        for (int i = 7; i >= 0; i--) begin
            sck = 1'b0;
            din = mosi[i];
            #HP;
            if (i == hold_bit) begin
                pause_n = 1'b0;
                #HP;
                repeat (3) begin
                    sck = 1'b1; din = ~din; #HP;
                    sck = 1'b0; #HP;
                end
                chk(host_dout_oe == 1'b0, "R7 output floats while paused", host_dout_oe, 0);
                if (cs_in_hold) begin
                    sel_n = 1'b1; #(2*HP);
                    sel_n = 1'b0; #HP;
                    chk(n_fe == 0 || host_dout_oe == 1'b0, "R7 select ignored in pause", n_fe, 0);
                end
                din = mosi[i];
                #HP;
                pause_n = 1'b1;
                #(2*HP);
            end
            miso[i] = host_dout;
            if (drv && !host_dout_oe) oe_ok = 0;
            sck = 1'b1;
            if (i == glitch_bit) begin
                #(HP/4); pause_n = 1'b0; #(HP/2); pause_n = 1'b1; #(HP/4);
            end else begin
                #HP;
            end
        end
    endtask

    task automatic clear_counts();
        rx_n = 0; n_fs = 0; n_fe = 0; n_req = 0; oe_seen = 0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(host_dout_oe == 0, "R1 oe low after reset", host_dout_oe, 0);
        chk(rx_valid == 0 && tx_req == 0 && frame_start == 0 && frame_end == 0,
            "R1 pulses low after reset", {rx_valid, tx_req, frame_start, frame_end}, 0);
    endtask

    task automatic t_mode0_two_bytes();
        logic [7:0] m0, m1;
        bit ok0, ok1;
        clear_counts();
        frame_begin(0, 8'h96, 1);
        xfer(8'hA5, 8'h96, 1, -1, 0, -1, m0, ok0);
        xfer(8'h3C, 8'h5A, 1, -1, 0, -1, m1, ok1);
        frame_finish();
        chk(rx_n == 2, "R2 two bytes received", rx_n, 2);
        chk(rx_log[0] == 8'hA5, "R2 first byte", rx_log[0], 8'hA5);
        chk(rx_log[1] == 8'h3C, "R2 second byte", rx_log[1], 8'h3C);
        chk(m0 == 8'h96, "R3 mode0 first outgoing byte", m0, 8'h96);
        chk(m1 == 8'h5A, "R3 mode0 second outgoing byte", m1, 8'h5A);
        chk(ok0 && ok1, "R9 oe high for driven bytes", {ok0, ok1}, 3);
        chk(n_fs == 1 && n_fe == 1, "R10 one open and one close pulse", n_fs * 16 + n_fe, 8'h11);
        chk(n_req == 3, "R10 requests at open and per byte", n_req, 3);
        chk(host_dout_oe == 0, "R5 oe low with select high", host_dout_oe, 0);
    endtask

    task automatic t_mode3();
        logic [7:0] m;
        bit ok;
        clear_counts();
        frame_begin(1, 8'h81, 1);
        xfer(8'hC3, 8'h81, 1, -1, 0, -1, m, ok);
        frame_finish();
        chk(rx_n == 1 && rx_log[0] == 8'hC3, "R4 mode3 byte received", rx_log[0], 8'hC3);
        chk(m == 8'h81, "R4 mode3 dummy fall does not shift", m, 8'h81);
    endtask

    task automatic t_no_drive();
        logic [7:0] m;
        bit ok;
        clear_counts();
        frame_begin(0, 8'hFF, 0);
        xfer(8'h12, 8'hFF, 0, -1, 0, -1, m, ok);
        frame_finish();
        chk(oe_seen == 0, "R9 undriven byte keeps output floating", oe_seen, 0);
        chk(rx_n == 1 && rx_log[0] == 8'h12, "R2 byte received without drive", rx_log[0], 8'h12);
    endtask

    task automatic t_abort();
        logic [7:0] m;
        bit ok;
        clear_counts();
        frame_begin(0, 8'h00, 1);
        for (int i = 0; i < 3; i++) begin
            sck = 1'b0; din = 1'b1; #HP;
            sck = 1'b1; #HP;
        end
        frame_finish();
        oe_seen = 0;
        for (int i = 0; i < 10; i++) begin
            sck = 1'b1; din = i[0]; #HP;
            sck = 1'b0; #HP;
        end
        chk(rx_n == 0, "R5 no byte from partial frame or idle clocks", rx_n, 0);
        chk(oe_seen == 0, "R5 output floats while deselected", oe_seen, 0);
        frame_begin(0, 8'h33, 1);
        xfer(8'h7E, 8'h33, 1, -1, 0, -1, m, ok);
        frame_finish();
        chk(rx_n == 1 && rx_log[0] == 8'h7E, "R5 new frame byte aligned", rx_log[0], 8'h7E);
        chk(m == 8'h33, "R5 new frame output aligned", m, 8'h33);
    endtask

    task automatic t_pause(input bit cs_pulse);
        logic [7:0] m;
        bit ok;
        clear_counts();
        frame_begin(0, 8'hB4, 1);
        xfer(8'h69, 8'hB4, 1, 4, cs_pulse, -1, m, ok);
        chk(n_fe == 0, "R7 no close pulse during pause", n_fe, 0);
        frame_finish();
        chk(rx_n == 1 && rx_log[0] == 8'h69, "R6 byte intact across pause", rx_log[0], 8'h69);
        chk(m == 8'hB4, "R6 output resumes at same bit", m, 8'hB4);
        chk(ok, "R6 output driven again after release", ok, 1);
    endtask

    task automatic t_glitch();
        logic [7:0] m;
        bit ok;
        clear_counts();
        frame_begin(0, 8'hE7, 1);
        xfer(8'h4D, 8'hE7, 1, -1, 0, 5, m, ok);
        frame_finish();
        chk(rx_n == 1 && rx_log[0] == 8'h4D, "R8 pause in clock high ignored (rx)", rx_log[0], 8'h4D);
        chk(m == 8'hE7 && ok, "R8 pause in clock high ignored (tx)", m, 8'hE7);
    endtask

    initial begin
        #500us;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        #20ns;
        rst_n = 1'b1;
        #20ns;
        t_reset();
        t_mode0_two_bytes();
        t_mode3();
        t_no_drive();
        t_abort();
        t_pause(0);
        t_pause(1);
        t_glitch();
        summary();
        $finish;
    end

endmodule